// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block turns a fast input clock into one narrow pulse every N input cycles. N is a 17-bit ratio word. The block counts it with a pulse-swallow arrangement: a dual-modulus prescaler runs at the input clock rate, and a main counter and a swallow counter sit behind it. The upper 13 bits of the word set the main count M and the lower 4 bits set the swallow count A. While the swallow counter is non-zero, the prescaler divides by 17. Once it reaches zero, the prescaler divides by 16 until the main counter reaches terminal count. The period is therefore 16·M + A input events.

An optional divide-by-two stage in front halves the rate of the events reaching the prescaler. This doubles every period and every step. The setting is static: it is chosen while the block is held in reset.

A new ratio is captured by a load strobe but does not act at once. It is held until the running period ends, so the output period never takes an intermediate value. A half-rate copy of the output toggles on every pulse so that the division can be observed at a lower speed.

Top module: `psw_divider`

## Requirements
- R1: After reset, `div_o` and `div_half_o` are low, and the active ratio is 240, so consecutive pulses are 240 input cycles apart (480 with the front halving stage on).
- R2: Bits [16:4] of the ratio word form the main count M and bits [3:0] form the swallow count A. With the front stage bypassed, pulses are exactly 16·M + A input cycles apart.
- R3: Ratios anywhere in 240 to 131071 are honoured exactly, including ratios whose swallow field is 0 and ratios whose swallow field is 15.
- R4: A loaded ratio below 240 behaves as 240, so no two pulses are ever closer than 240 input cycles (the swallow count never exceeds the main count).
- R5: With `halve_en_i` high, pulses are exactly twice the clamped ratio apart (480 to 262142 input cycles).
- R6: Each output pulse is high for exactly one input clock cycle.
- R7: A ratio loaded in the middle of a period does not change that period. It first governs the period that starts at the next terminal count.
- R8: A load strobe in the same cycle as a terminal count takes effect for the period that starts at that terminal count.
- R9: `div_half_o` changes state exactly when a pulse is issued and holds its state otherwise, giving a square wave at half the pulse rate.

Top module port list order is clock, reset, ratio, load, halve enable, pulse, half-rate output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock being divided |
| rst_ni | input | 1 | Active-low synchronous reset |
| ratio_i | input | 17 | Requested ratio: main count in [16:4], swallow count in [3:0] |
| load_i | input | 1 | One-cycle strobe that captures `ratio_i` |
| halve_en_i | input | 1 | Enables the front divide-by-two stage; static while running |
| div_o | output | 1 | One-cycle pulse at each main terminal count |
| div_half_o | output | 1 | Toggles on each pulse (output divided by two) |

## Verification
A load strobe and a terminal count can fall in the same cycle. In that case the new ratio must reach the counters reloading at that moment and must not wait a further period. The bench times this case exactly. It synchronises on one pulse, counts off one fewer cycles than the known old period, and raises the strobe so that it is sampled on the terminal edge. The bench then judges two things: the period just ending still equals the old ratio, and the very next period equals the new ratio. A separate case raises the strobe mid-period and checks that the running period is left intact.

// File: rtl/psw_pkg.sv
package psw_pkg;

    // Default field widths of the ratio word.
    localparam int unsigned PSW_MAIN_W    = 13;
    localparam int unsigned PSW_SWALLOW_W = 4;
    localparam int unsigned PSW_MIN_RATIO = 240;

    // Operating mode of the stage in front of the prescaler.
    typedef enum logic {
        FRONT_BYPASS = 1'b0,
        FRONT_HALVE  = 1'b1
    } front_mode_e;

    // Floor a requested ratio at the smallest legal value.
    function automatic int unsigned psw_floor(input int unsigned req,
                                              input int unsigned lo);
        return (req < lo) ? lo : req;
    endfunction

endpackage

// File: rtl/psw_front.sv
module psw_front (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic halve_en_i,
    output logic ce_o
);
    import psw_pkg::*;

    typedef struct packed {
        logic phase;
    } front_st_t;

    front_st_t   st_d, st_q;
    front_mode_e mode;

    always_comb begin
        mode       = halve_en_i ? FRONT_HALVE : FRONT_BYPASS;
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        unique case (mode)
            FRONT_HALVE:  ce_o = st_q.phase;
            default:      ce_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psw_ratio_reg.sv
module psw_ratio_reg #(
    parameter int unsigned M_W       = psw_pkg::PSW_MAIN_W,
    parameter int unsigned A_W       = psw_pkg::PSW_SWALLOW_W,
    parameter int unsigned MIN_RATIO = psw_pkg::PSW_MIN_RATIO,
    parameter int unsigned RST_RATIO = psw_pkg::PSW_MIN_RATIO
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [M_W+A_W-1:0]   ratio_i,
    input  logic                 load_i,
    input  logic                 boundary_i,
    output logic [M_W+A_W-1:0]   reload_ratio_o
);
    import psw_pkg::*;

    localparam int unsigned      RATIO_W = M_W + A_W;
    localparam logic [RATIO_W-1:0] FLOOR_R = RATIO_W'(MIN_RATIO);
    localparam logic [RATIO_W-1:0] RESET_R = RATIO_W'(psw_floor(RST_RATIO, MIN_RATIO));

    typedef struct packed {
        logic [RATIO_W-1:0] pending;
        logic               pend_vld;
        logic [RATIO_W-1:0] active;
    } ratio_st_t;

    ratio_st_t          st_d, st_q;
    logic [RATIO_W-1:0] req_clamped;

    always_comb begin
        req_clamped = (ratio_i < FLOOR_R) ? FLOOR_R : ratio_i;

        // Ratio the counters pick up at the next terminal count; a load in
        // this very cycle is forwarded directly.
        if (load_i) begin
            reload_ratio_o = req_clamped;
        end else if (st_q.pend_vld) begin
            reload_ratio_o = st_q.pending;
        end else begin
            reload_ratio_o = st_q.active;
        end

        st_d = st_q;
        if (boundary_i) begin
            st_d.active   = reload_ratio_o;
            st_d.pend_vld = 1'b0;
        end else if (load_i) begin
            st_d.pending  = req_clamped;
            st_d.pend_vld = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.pending  <= RESET_R;
            st_q.pend_vld <= 1'b0;
            st_q.active   <= RESET_R;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
    parameter int unsigned A_W = psw_pkg::PSW_SWALLOW_W
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ce_i,
    input  logic swallow_i,
    output logic pulse_o
);
    // Base modulus is 2**A_W; one extra count while swallowing.
    localparam int unsigned BASE = 1 << A_W;
    localparam int unsigned PC_W = $clog2(BASE + 1);
    localparam logic [PC_W-1:0] LAST_LO = PC_W'(BASE - 1);
    localparam logic [PC_W-1:0] LAST_HI = PC_W'(BASE);

    typedef struct packed {
        logic [PC_W-1:0] cnt;
    } pre_st_t;

    pre_st_t         st_d, st_q;
    logic [PC_W-1:0] last;

    always_comb begin
        last    = swallow_i ? LAST_HI : LAST_LO;
        pulse_o = ce_i && (st_q.cnt == last);
        st_d    = st_q;
        if (pulse_o) begin
            st_d.cnt = '0;
        end else if (ce_i) begin
            st_d.cnt = st_q.cnt + PC_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psw_swallow_ctr.sv
module psw_swallow_ctr #(
    parameter int unsigned M_W       = psw_pkg::PSW_MAIN_W,
    parameter int unsigned A_W       = psw_pkg::PSW_SWALLOW_W,
    parameter int unsigned MIN_RATIO = psw_pkg::PSW_MIN_RATIO,
    parameter int unsigned RST_RATIO = psw_pkg::PSW_MIN_RATIO
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 pulse_i,
    input  logic [M_W+A_W-1:0]   reload_ratio_i,
    output logic                 terminal_o,
    output logic                 swallow_o,
    output logic [M_W-1:0]       m_left_o,
    output logic [A_W-1:0]       a_left_o
);
    import psw_pkg::*;

    localparam int unsigned        RATIO_W = M_W + A_W;
    localparam logic [RATIO_W-1:0] RESET_R = RATIO_W'(psw_floor(RST_RATIO, MIN_RATIO));

    typedef struct packed {
        logic [M_W-1:0] m_left;
        logic [A_W-1:0] a_left;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        swallow_o  = (st_q.a_left != '0);
        terminal_o = pulse_i && (st_q.m_left == M_W'(1));
        st_d       = st_q;
        if (terminal_o) begin
            st_d.m_left = reload_ratio_i[RATIO_W-1:A_W];
            st_d.a_left = reload_ratio_i[A_W-1:0];
        end else if (pulse_i) begin
            st_d.m_left = st_q.m_left - M_W'(1);
            if (swallow_o) begin
                st_d.a_left = st_q.a_left - A_W'(1);
            end
        end
        m_left_o = st_q.m_left;
        a_left_o = st_q.a_left;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.m_left <= RESET_R[RATIO_W-1:A_W];
            st_q.a_left <= RESET_R[A_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/psw_divider.sv
module psw_divider #(
    parameter int unsigned M_W       = psw_pkg::PSW_MAIN_W,
    parameter int unsigned A_W       = psw_pkg::PSW_SWALLOW_W,
    parameter int unsigned MIN_RATIO = psw_pkg::PSW_MIN_RATIO,
    parameter int unsigned RST_RATIO = psw_pkg::PSW_MIN_RATIO
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [M_W+A_W-1:0] ratio_i,
    input  logic               load_i,
    input  logic               halve_en_i,
    output logic               div_o,
    output logic               div_half_o
);
    localparam int unsigned RATIO_W = M_W + A_W;

    typedef struct packed {
        logic pulse;
        logic half;
    } out_st_t;

    logic               stage_ce;
    logic               pre_pulse;
    logic               swallow;
    logic               terminal;
    logic [RATIO_W-1:0] reload_ratio;
    logic [M_W-1:0]     m_left;
    logic [A_W-1:0]     a_left;
    out_st_t            out_d, out_q;

    psw_front u_front (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .halve_en_i (halve_en_i),
        .ce_o       (stage_ce)
    );

    psw_ratio_reg #(
        .M_W       (M_W),
        .A_W       (A_W),
        .MIN_RATIO (MIN_RATIO),
        .RST_RATIO (RST_RATIO)
    ) u_ratio (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .ratio_i        (ratio_i),
        .load_i         (load_i),
        .boundary_i     (terminal),
        .reload_ratio_o (reload_ratio)
    );

    psw_prescaler #(
        .A_W (A_W)
    ) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ce_i      (stage_ce),
        .swallow_i (swallow),
        .pulse_o   (pre_pulse)
    );

    psw_swallow_ctr #(
        .M_W       (M_W),
        .A_W       (A_W),
        .MIN_RATIO (MIN_RATIO),
        .RST_RATIO (RST_RATIO)
    ) u_ctr (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .pulse_i        (pre_pulse),
        .reload_ratio_i (reload_ratio),
        .terminal_o     (terminal),
        .swallow_o      (swallow),
        .m_left_o       (m_left),
        .a_left_o       (a_left)
    );

    always_comb begin
        out_d.pulse = terminal;
        out_d.half  = out_q.half ^ terminal;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign div_o      = out_q.pulse;
    assign div_half_o = out_q.half;

endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk #(
    parameter int unsigned M_W       = psw_pkg::PSW_MAIN_W,
    parameter int unsigned A_W       = psw_pkg::PSW_SWALLOW_W,
    parameter int unsigned MIN_RATIO = psw_pkg::PSW_MIN_RATIO
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           div_o,
    input logic           div_half_o,
    input logic [M_W-1:0] m_left,
    input logic [A_W-1:0] a_left
);
    localparam int unsigned GAP_W = $clog2(MIN_RATIO + 1) + 1;
    localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(MIN_RATIO - 1);

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Cycles since the previous pulse, saturating above the legal minimum.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (div_o) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q <= GAP_MIN) begin
            gap_q  <= gap_q + GAP_W'(1);
        end
    end

    a_r6_single_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_o |=> !div_o);

    a_r9_half_flips_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(div_o) |-> (div_half_o != $past(div_half_o)));

    a_r9_half_holds_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !div_o |-> $stable(div_half_o));

    a_r4_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_o && seen_q) |-> (gap_q >= GAP_MIN));

    a_r2_swallow_within_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (M_W'(a_left) <= m_left));

endmodule

bind psw_divider psw_divider_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_o      (div_o),
    .div_half_o (div_half_o),
    .m_left     (m_left),
    .a_left     (a_left)
);

// File: tb/psw_divider_tb.sv
module psw_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] ratio = '0;
    logic        load = 1'b0;
    logic        halve = 1'b0;
    logic        div_o;
    logic        div_half_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit halve_now = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    psw_divider u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ratio_i    (ratio),
        .load_i     (load),
        .halve_en_i (halve),
        .div_o      (div_o),
        .div_half_o (div_half_o)
    );

    function automatic int exp_period(input int r, input bit h);
        int eff;
        eff = (r < 240) ? 240 : r;
        return h ? 2 * eff : eff;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int t);
        do @(negedge clk); while (!div_o);
        t = cyc;
    endtask

    task automatic do_reset(input bit h);
        @(negedge clk);
        rst_n = 1'b0;
        halve = h;
        halve_now = h;
        load = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Load r, wait for the boundary, measure the following period.
    task automatic load_and_measure(input string req, input int r);
        int t0, t1;
        bit h0;
        @(negedge clk);
        ratio = 17'(r);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        wait_pulse(t0);
        h0 = div_half_o;
        wait_pulse(t1);
        chk(req, t1 - t0, exp_period(r, halve_now));
        chk("R9 half toggles", int'(div_half_o), int'(!h0));
    endtask

    initial begin
        int t0, t1, t2, pold, rnd;
        rnd = int'($urandom(32'd2024));

        // Phase A: front halving stage on
        do_reset(1'b1);
        @(negedge clk);
        chk("R1 reset div_o", int'(div_o), 0);
        chk("R1 reset div_half_o", int'(div_half_o), 0);
        wait_pulse(t0);
        wait_pulse(t1);
        chk("R1/R5 reset ratio halved", t1 - t0, 480);
        load_and_measure("R5 halved 300", 300);
        load_and_measure("R5/R4 halved clamp 100", 100);

        // Phase B: front stage bypassed
        do_reset(1'b0);
        wait_pulse(t0);
        @(negedge clk);
        chk("R6 pulse one cycle", int'(div_o), 0);
        wait_pulse(t1);
        chk("R1 reset ratio", t1 - t0, 240);
        load_and_measure("R3 ratio 240", 240);
        load_and_measure("R2/R3 swallow 0", 16 * 20);
        load_and_measure("R2/R3 swallow 15", 16 * 20 + 15);
        load_and_measure("R4 clamp 0", 0);
        load_and_measure("R4 clamp 239", 239);
        for (int i = 0; i < 5; i++) begin
            rnd = 240 + int'($urandom % 760);
            load_and_measure("R2 random ratio", rnd);
        end

        // R7: mid-period load leaves the running period alone
        load_and_measure("R2 ratio 500", 500);
        wait_pulse(t0);
        repeat (200) @(negedge clk);
        ratio = 17'd700;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        wait_pulse(t1);
        chk("R7 running period kept", t1 - t0, 500);
        wait_pulse(t2);
        chk("R7 new period next", t2 - t1, 700);

        // R8: load sampled on the terminal edge itself
        pold = 700;
        t0 = t2;
        repeat (pold - 1) @(negedge clk);
        ratio = 17'd257;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R8 pulse on boundary", int'(div_o), 1);
        t1 = cyc;
        chk("R8 old period ends", t1 - t0, pold);
        wait_pulse(t2);
        chk("R8 new ratio at once", t2 - t1, 257);

        // Largest ratio last
        load_and_measure("R3 ratio 131071", 131071);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1..R9 actual=%0d expected<195000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule